// File: doc/BRIEF.md
# Parallel Flash Write-Strobe Qualifier

This block turns the asynchronous write strobes of a byte-wide parallel memory bus into clean, synchronous write events for an internal command engine. The three active-low controls (chip enable, write enable, output enable) are brought into the fast clock domain through two-flop synchronisers. Each then passes a pulse-width filter that ignores any level shorter than `MIN_PW` clock samples. A write cycle exists only while chip and write enable are both low and output enable is high. The address is taken when that condition first becomes true, which is the later of the two falling edges. The data is taken when the condition ends through the earlier of the two rising edges.

When a qualified write ends, the block raises a one-clock `wr_valid` pulse, presenting the captured address and data together. A lockout input, driven by external supply monitoring, blocks all writes while asserted and is forwarded, synchronised, as a reset to the command engine. A cycle still in progress when reset is released or the lockout clears is never reported.

The block assumes the bus holds address and data stable for at least `MIN_PW + 4` clocks after the qualifying edges, so that the synchronisation delay does not move the capture point onto the wrong value.

Top module: `flash_wr_qualifier`

## Requirements
- R1: After reset with an idle bus, `wr_valid` is 0, `wr_addr` and `wr_data` are 0 and `eng_reset` is 0.
- R2: Each write cycle (chip enable low and write enable low, with output enable high) yields exactly one `wr_valid` pulse, one clock wide, whichever strobe falls first or rises first.
- R3: `wr_addr` carries the bus address present when the later of the two enable strobes fell. It keeps its value between events.
- R4: `wr_data` carries the bus data present when the earlier of the two enable strobes rose.
- R5: If output enable goes low while chip enable and write enable are low, no event is produced for that cycle.
- R6: A low pulse on chip enable or write enable lasting fewer than `MIN_PW` (default 3) clock samples starts no write. A pulse of exactly `MIN_PW` samples does start one. A high pulse shorter than `MIN_PW` during a cycle neither splits it nor ends it.
- R7: `eng_reset` follows `supply_low` two clocks later. While it is high, no event is produced, including for a cycle that ends during the lockout.
- R8: A write cycle already active when reset is released produces no event. The next full cycle is accepted.
- R9: A cycle that is active when the lockout clears produces no event.
- R10: `wr_valid` appears in the sample taken `MIN_PW + 3` clocks after the ending strobe edge is driven, between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fl_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| fl_we_n | input | 1 | Bus write enable, active low, asynchronous |
| fl_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| fl_addr | input | AW | Bus address |
| fl_data | input | DW | Bus data |
| supply_low | input | 1 | Low-supply lockout request, asynchronous |
| wr_valid | output | 1 | One-clock write event |
| wr_addr | output | AW | Address of the last write event |
| wr_data | output | DW | Data of the last write event |
| eng_reset | output | 1 | Synchronised reset to the command engine |

## Verification
A corrupted filter count or a wrong sequencer state shows at the ports as one of four faults: a missing or doubled `wr_valid` pulse, a pulse for a cycle that should have been dropped, or a pulse with the address or data of the wrong edge. Any of these is visible within `MIN_PW + 3` clocks of the strobe edge that ends the cycle. Output-enable aborts, short pulses and lockout transitions are each placed against a cycle whose correct outcome is known. Every error therefore becomes a wrong event count or a wrong captured value at that point.

// File: rtl/flash_wq_pkg.sv
// Shared types for the write-strobe qualifier.
package flash_wq_pkg;
    // Sequencer states: power-up settle, blocked, idle, cycle in progress.
    typedef enum logic [1:0] {
        ST_PWRUP = 2'd0,
        ST_BLOCK = 2'd1,
        ST_IDLE  = 2'd2,
        ST_WRITE = 2'd3
    } wq_state_e;
endpackage

// File: rtl/fwq_sync2.sv
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes each bit is sampled independently; no coherence across bits.
module fwq_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/fwq_glitch_filter.sv
// Pulse-width filter: the output adopts a new level only after the input
// has shown that level for MIN_PW consecutive samples.
// Assumes a synchronised input.
module fwq_glitch_filter #(
    parameter int   MIN_PW  = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic filt_o
);
    localparam int              CNT_W = $clog2(MIN_PW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PW - 1);

    logic [CNT_W-1:0] run_q;

    // Count consecutive differing samples; flip the output at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            filt_o <= RST_VAL;
        end else if (sync_i == filt_o) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q  <= '0;
            filt_o <= sync_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R6: the output only moves to a level the input has just presented.
    p_filter_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> ($past(sync_i) == filt_o));
endmodule

// File: rtl/fwq_cycle_seq.sv
// Write-cycle sequencer: tracks the combined filtered strobes, captures the
// address at cycle start and the data at cycle end, and emits one event.
// Assumes filtered, synchronised strobes and a synchronised lockout.
module fwq_cycle_seq
    import flash_wq_pkg::*;
#(
    parameter int AW     = 19,
    parameter int DW     = 8,
    parameter int MIN_PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_f,
    input  logic          we_f,
    input  logic          oe_f,
    input  logic          lock,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int             PU_CYC = MIN_PW + 4;
    localparam int             PU_W   = $clog2(PU_CYC + 1);
    localparam logic [PU_W-1:0] PU_LAST = PU_W'(PU_CYC - 1);

    wq_state_e      st_q;
    logic [PU_W-1:0] pu_q;
    logic [AW-1:0]  addr_q;
    logic           active;

    // Write qualified: both enables low, output enable high.
    assign active = !ce_f && !we_f && oe_f;

    // State, captures and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_PWRUP;
            pu_q     <= '0;
            addr_q   <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            unique case (st_q)
                ST_PWRUP: begin
                    if (pu_q == PU_LAST) st_q <= ST_BLOCK;
                    else                 pu_q <= pu_q + 1'b1;
                end
                ST_BLOCK: begin
                    if (!lock && !active) st_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (lock) begin
                        st_q <= ST_BLOCK;
                    end else if (active) begin
                        st_q   <= ST_WRITE;
                        addr_q <= bus_addr;
                    end
                end
                ST_WRITE: begin
                    if (lock) begin
                        st_q <= ST_BLOCK;
                    end else if (!active) begin
                        st_q <= ST_IDLE;
                        if (oe_f) begin
                            wr_valid <= 1'b1;
                            wr_addr  <= addr_q;
                            wr_data  <= bus_data;
                        end
                    end
                end
                default: st_q <= ST_BLOCK;
            endcase
        end
    end

    // R2: an event lasts a single clock.
    p_event_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    // R2: an event only leaves an in-progress cycle.
    p_event_from_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(st_q) == ST_WRITE));
    // R3: the reported address holds between events.
    p_addr_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> $stable(wr_addr));
    // R7: lockout suppresses the next event and forces the blocked state.
    p_lock_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !wr_valid);
    p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && st_q != ST_PWRUP) |=> (st_q == ST_BLOCK));
    // R8/R9: leaving the blocked state needs an inactive bus.
    p_block_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && $past(st_q) == ST_BLOCK) |-> !$past(active));
endmodule

// File: rtl/flash_wr_qualifier.sv
// Top of the write-strobe qualifier: synchronises bus strobes and the
// lockout, filters strobe glitches and sequences write cycles.
// Assumes bus address/data stay stable MIN_PW+4 clocks past each edge.
module flash_wr_qualifier #(
    parameter int AW     = 19,
    parameter int DW     = 8,
    parameter int MIN_PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fl_ce_n,
    input  logic          fl_we_n,
    input  logic          fl_oe_n,
    input  logic [AW-1:0] fl_addr,
    input  logic [DW-1:0] fl_data,
    input  logic          supply_low,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          eng_reset
);
    localparam int NSTRB = 3;

    logic [NSTRB-1:0] strb_s;
    logic [NSTRB-1:0] strb_f;
    logic             lock_s;

    // Strobes: bit 0 chip enable, bit 1 write enable, bit 2 output enable.
    fwq_sync2 #(.W(NSTRB), .RST_VAL({NSTRB{1'b1}})) u_strb_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({fl_oe_n, fl_we_n, fl_ce_n}),
        .sync_o(strb_s)
    );

    fwq_sync2 #(.W(1), .RST_VAL(1'b0)) u_lock_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i(supply_low),
        .sync_o(lock_s)
    );

    // One filter per strobe.
    for (genvar g = 0; g < NSTRB; g++) begin : g_filt
        fwq_glitch_filter #(.MIN_PW(MIN_PW), .RST_VAL(1'b1)) u_filt (
            .clk(clk), .rst_n(rst_n),
            .sync_i(strb_s[g]),
            .filt_o(strb_f[g])
        );
    end

    fwq_cycle_seq #(.AW(AW), .DW(DW), .MIN_PW(MIN_PW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ce_f(strb_f[0]), .we_f(strb_f[1]), .oe_f(strb_f[2]),
        .lock(lock_s),
        .bus_addr(fl_addr), .bus_data(fl_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign eng_reset = lock_s;

    // R7: the engine reset tracks the lockout input two clocks later.
    p_eng_reset_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(supply_low, 2)) |-> eng_reset);
endmodule

// File: tb/flash_wr_qualifier_tb_top.sv
module flash_wr_qualifier_tb_top;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int MIN_PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic wr_valid, eng_reset;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0, failures = 0;
    int cyc = 0, ev_cnt = 0, ev_cyc = 0, multi = 0;
    logic prev_valid = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    flash_wr_qualifier #(.AW(AW), .DW(DW), .MIN_PW(MIN_PW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fl_ce_n(ce_n), .fl_we_n(we_n), .fl_oe_n(oe_n),
        .fl_addr(addr), .fl_data(data), .supply_low(supply_low),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_reset(eng_reset)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Event monitor sampled between edges.
    always @(negedge clk) begin
        if (wr_valid) begin
            ev_cnt = ev_cnt + 1;
            ev_cyc = cyc;
            last_addr = wr_addr;
            last_data = wr_data;
            if (prev_valid) multi = multi + 1;
        end
        prev_valid = wr_valid;
    end

    // Vector: {ce falls first, ce rises first, early addr, late addr, first data, late data}
    localparam int VN = 6;
    localparam logic [55:0] VEC [VN] = '{
        {1'b1, 1'b1, 19'h00100, 19'h7ABCD, 8'h55, 8'hAA},
        {1'b1, 1'b0, 19'h01234, 19'h00F0F, 8'hC3, 8'h3C},
        {1'b0, 1'b1, 19'h7FFFF, 19'h00000, 8'h01, 8'hFE},
        {1'b0, 1'b0, 19'h2AAAA, 19'h55555, 8'h80, 8'h7F},
        {1'b1, 1'b0, 19'h00555, 19'h002AA, 8'hA0, 8'h0A},
        {1'b0, 1'b1, 19'h12345, 19'h6789A, 8'hFF, 8'h00}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic ce_fall_1st, input logic ce_rise_1st,
                             input logic [AW-1:0] a_early, input logic [AW-1:0] a_late,
                             input logic [DW-1:0] d_first, input logic [DW-1:0] d_late);
        @(negedge clk);
        addr = a_early; data = '0;
        if (ce_fall_1st) ce_n = 1'b0; else we_n = 1'b0;
        wait_n(6);
        addr = a_late;
        if (ce_fall_1st) we_n = 1'b0; else ce_n = 1'b0;
        wait_n(10);
        addr = ~a_late; data = d_first;
        wait_n(2);
        if (ce_rise_1st) ce_n = 1'b1; else we_n = 1'b1;
        wait_n(10);
        data = d_late;
        wait_n(2);
        if (ce_rise_1st) we_n = 1'b1; else ce_n = 1'b1;
        wait_n(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int e0;
        wait_n(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wr_valid", wr_valid, 0);
        check("R1 wr_addr", wr_addr, 0);
        check("R1 wr_data", wr_data, 0);
        check("R1 eng_reset", eng_reset, 0);
        wait_n(15);

        // R2/R3/R4 vector table
        for (int i = 0; i < VN; i++) begin
            e0 = ev_cnt;
            bus_write(VEC[i][55], VEC[i][54], VEC[i][53:35], VEC[i][34:16],
                      VEC[i][15:8], VEC[i][7:0]);
            check("R2 one event", ev_cnt - e0, 1);
            check("R3 later-fall addr", last_addr, VEC[i][34:16]);
            check("R4 earlier-rise data", last_data, VEC[i][15:8]);
        end
        check("R2 single-clock pulse", multi, 0);

        // R5 output enable falls mid-cycle
        e0 = ev_cnt;
        ce_n = 1'b0; we_n = 1'b0; wait_n(10);
        oe_n = 1'b0; wait_n(10);
        ce_n = 1'b1; we_n = 1'b1; wait_n(10);
        oe_n = 1'b1; wait_n(10);
        check("R5 oe abort", ev_cnt - e0, 0);

        // R6 short low pulse on we, then on ce
        e0 = ev_cnt;
        ce_n = 1'b0; wait_n(10);
        we_n = 1'b0; wait_n(MIN_PW - 1); we_n = 1'b1; wait_n(12);
        ce_n = 1'b1; wait_n(10);
        we_n = 1'b0; wait_n(10);
        ce_n = 1'b0; wait_n(MIN_PW - 1); ce_n = 1'b1; wait_n(12);
        we_n = 1'b1; wait_n(10);
        check("R6 short pulses rejected", ev_cnt - e0, 0);
        // R6 pulse of exactly MIN_PW accepted
        e0 = ev_cnt;
        ce_n = 1'b0; wait_n(10);
        we_n = 1'b0; wait_n(MIN_PW); we_n = 1'b1; wait_n(12);
        ce_n = 1'b1; wait_n(10);
        check("R6 min pulse accepted", ev_cnt - e0, 1);
        // R6 short high glitch inside a cycle
        e0 = ev_cnt;
        addr = 19'h0BEEF; ce_n = 1'b0; we_n = 1'b0; wait_n(10);
        we_n = 1'b1; wait_n(MIN_PW - 1); we_n = 1'b0; wait_n(10);
        data = 8'h3C; wait_n(2);
        we_n = 1'b1; wait_n(10);
        ce_n = 1'b1; wait_n(10);
        check("R6 glitch no split", ev_cnt - e0, 1);
        check("R6 glitch data", last_data, 8'h3C);

        // R10 latency from ending edge
        data = 8'h99; ce_n = 1'b0; we_n = 1'b0; wait_n(10);
        e0 = cyc;
        we_n = 1'b1; wait_n(12);
        check("R10 latency", ev_cyc - e0, MIN_PW + 3);
        ce_n = 1'b1; wait_n(10);

        // R7 lockout
        supply_low = 1'b1; @(negedge clk);
        check("R7 eng_reset after 1", eng_reset, 0);
        @(negedge clk);
        check("R7 eng_reset after 2", eng_reset, 1);
        e0 = ev_cnt;
        bus_write(1'b1, 1'b1, 19'h1, 19'h2, 8'h11, 8'h22);
        check("R7 write ignored", ev_cnt - e0, 0);
        // R9 lockout clears mid-cycle
        ce_n = 1'b0; we_n = 1'b0; wait_n(10);
        supply_low = 1'b0; wait_n(10);
        check("R9 eng_reset released", eng_reset, 0);
        we_n = 1'b1; ce_n = 1'b1; wait_n(10);
        check("R9 cycle dropped", ev_cnt - e0, 0);
        // R7 lockout arrives mid-cycle
        ce_n = 1'b0; we_n = 1'b0; wait_n(10);
        supply_low = 1'b1; wait_n(4);
        we_n = 1'b1; ce_n = 1'b1; wait_n(10);
        supply_low = 1'b0; wait_n(10);
        check("R7 mid-cycle lock", ev_cnt - e0, 0);
        bus_write(1'b0, 1'b0, 19'h3, 19'h4, 8'h44, 8'h55);
        check("R9 recovery", ev_cnt - e0, 1);

        // R8 power-up with active cycle
        rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        wait_n(5);
        rst_n = 1'b1; wait_n(20);
        e0 = ev_cnt;
        we_n = 1'b1; wait_n(10);
        ce_n = 1'b1; wait_n(10);
        check("R8 power-up cycle ignored", ev_cnt - e0, 0);
        bus_write(1'b1, 1'b0, 19'h10, 19'h20, 8'h66, 8'h77);
        check("R8 next cycle accepted", ev_cnt - e0, 1);
        check("R8 next cycle addr", last_addr, 19'h20);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule